// File: doc/BRIEF.md
# Coded-Prescaler PWM Channel

A single pulse-width-modulation channel run from a 24 MHz source clock. A 4-bit prescaler code picks one of a sparse, non-linear set of divide ratios (1 up to 72000). A period field and an active field, both counted in prescaled cycles, then shape the waveform. The period field stores the cycle count minus one. A bypass mode routes the raw source clock straight to the pin. All settings sit in a small synchronous register file with a write strobe and a combinational read-back.

Software brings the channel up by setting the gate bit first and the enable bit second. It takes the channel down in the reverse order. The output shows a waveform only while both bits are set. Period and active values written while the channel runs are held back until the current period ends, so a pulse is never cut short or stretched.

Register map (word addresses on `regAddr`):
- 0, control: bit 0 enable, bit 1 clock gate, bit 2 bypass, bit 3 polarity (1 = normal, active high), bits 7:4 prescaler code.
- 1: period field, bits 15:0.
- 2: active field, bits 15:0.
- 3: unused.

Top module: `pwm_coded_chan`

## Requirements
- R1: After reset every register reads 0. Because the polarity bit resets to 0 (inverted), `pwmOut` sits at its inactive level, which is 1.
- R2: A read of addresses 0, 1 or 2 returns the last written value, masked to the field bits: 8 bits for control, 16 bits for period and 16 bits for active. All other bit positions read 0, and address 3 always reads 0.
- R3: The channel runs only while both gate and enable are set. Otherwise the internal counters hold at zero and `pwmOut` is at the inactive level, which is the inverse of the polarity bit.
- R4: Prescaler code 15 divides by 1. Codes 0 to 4 divide by 120, 180, 240, 360 and 480. Codes 8 to 12 divide by 12000, 24000, 36000, 48000 and 72000.
- R5: Codes 5, 6, 7, 13 and 14 divide by 1.
- R6: One PWM period lasts (period field + 1) prescaled cycles. Counting starts at the clock edge that makes the channel run.
- R7: Within each period, the output is at the active level for the first A prescaled cycles, where A is the active field, and at the inactive level for the rest.
- R8: An active field of 0 keeps the output inactive for the whole period. An active field at or above the period field + 1 keeps it active for the whole period.
- R9: With the polarity bit at 1, the active level is high. With it at 0, the active level is low.
- R10: Period and active values written while the channel runs take effect only at the next period boundary. While the channel is stopped, the values take effect at once.
- R11: While the channel runs with bypass set, `pwmOut` follows the source clock. Prescaler, period, active and polarity settings have no effect in this mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 24 MHz source clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 2 | Register word address for write and read |
| wrEn | input | 1 | Write strobe, captured on the rising clock edge |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data for `regAddr` |
| pwmOut | output | 1 | PWM pin |

## Verification
The assertions assume bypass is off whenever they compare the pin against a level. In bypass the pin is the clock itself, so no edge-sampled check can speak to it. The bench therefore tests bypass by sampling the pin in the middle of each clock phase. The checks also assume reset is released away from a clock edge and that `regAddr` and `wrEn` change only between edges. The stimulus drives all inputs on the falling edge to meet this.

// File: rtl/pwm_coded_pkg.sv
package pwm_coded_pkg;

  localparam int CNT_W  = 16;
  localparam int DIV_W  = 17;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 2;
  localparam int CODE_W = 4;

  // Control strobes from the register side to the waveform datapath.
  typedef struct packed {
    logic             run;
    logic             bypass;
    logic             polNormal;
    logic [DIV_W-1:0] divM1;
  } pwmStrobe_t;

  // Prescaler code to (ratio - 1); unlisted codes fall back to ratio 1.
  function automatic logic [DIV_W-1:0] codeToDivM1(input logic [CODE_W-1:0] code);
    logic [DIV_W-1:0] r;
    case (code)
      4'd0:    r = DIV_W'(119);
      4'd1:    r = DIV_W'(179);
      4'd2:    r = DIV_W'(239);
      4'd3:    r = DIV_W'(359);
      4'd4:    r = DIV_W'(479);
      4'd8:    r = DIV_W'(11999);
      4'd9:    r = DIV_W'(23999);
      4'd10:   r = DIV_W'(35999);
      4'd11:   r = DIV_W'(47999);
      4'd12:   r = DIV_W'(71999);
      default: r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pwm_coded_ctrl.sv
module pwm_coded_ctrl
  import pwm_coded_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] regAddr,
  input  logic          wrEn,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData,
  output pwmStrobe_t    strobe,
  output logic [CW-1:0] periodLive,
  output logic [CW-1:0] activeLive
);

  localparam logic [AW-1:0] ADDR_CTRL   = AW'(0);
  localparam logic [AW-1:0] ADDR_PERIOD = AW'(1);
  localparam logic [AW-1:0] ADDR_ACTIVE = AW'(2);
  localparam int CTRL_W = 4 + CODE_W;

  logic              enBit;
  logic              gateBit;
  logic              bypassBit;
  logic              polBit;
  logic [CODE_W-1:0] preCode;
  logic [CW-1:0]     periodReg;
  logic [CW-1:0]     activeReg;
  logic [CTRL_W-1:0] ctrlWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enBit     <= 1'b0;
      gateBit   <= 1'b0;
      bypassBit <= 1'b0;
      polBit    <= 1'b0;
      preCode   <= '0;
      periodReg <= '0;
      activeReg <= '0;
    end else if (wrEn) begin
      case (regAddr)
        ADDR_CTRL: begin
          enBit     <= wrData[0];
          gateBit   <= wrData[1];
          bypassBit <= wrData[2];
          polBit    <= wrData[3];
          preCode   <= wrData[4 +: CODE_W];
        end
        ADDR_PERIOD: periodReg <= wrData[CW-1:0];
        ADDR_ACTIVE: activeReg <= wrData[CW-1:0];
        default: ;
      endcase
    end
  end

  assign ctrlWord = {preCode, polBit, bypassBit, gateBit, enBit};

  always_comb begin
    rdData = '0;
    case (regAddr)
      ADDR_CTRL:   rdData[CTRL_W-1:0] = ctrlWord;
      ADDR_PERIOD: rdData[CW-1:0]     = periodReg;
      ADDR_ACTIVE: rdData[CW-1:0]     = activeReg;
      default:     rdData             = '0;
    endcase
  end

  always_comb begin
    strobe.run       = enBit & gateBit;
    strobe.bypass    = bypassBit;
    strobe.polNormal = polBit;
    strobe.divM1     = codeToDivM1(preCode);
  end

  assign periodLive = periodReg;
  assign activeLive = activeReg;

endmodule

// File: rtl/pwm_coded_dp.sv
module pwm_coded_dp
  import pwm_coded_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int VW = DIV_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          srcClk,
  input  pwmStrobe_t    strobe,
  input  logic [CW-1:0] periodLive,
  input  logic [CW-1:0] activeLive,
  output logic          pwmOut,
  output logic [CW-1:0] cycCnt,
  output logic [VW-1:0] preCnt,
  output logic [CW-1:0] periodSh,
  output logic [CW-1:0] activeSh
);

  logic preTick;
  logic periodEnd;
  logic activeLvl;
  logic waveLvl;

  assign preTick   = (preCnt >= strobe.divM1);
  assign periodEnd = preTick && (cycCnt == periodSh);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt   <= '0;
      cycCnt   <= '0;
      periodSh <= '0;
      activeSh <= '0;
    end else if (!strobe.run) begin
      preCnt   <= '0;
      cycCnt   <= '0;
      periodSh <= periodLive;
      activeSh <= activeLive;
    end else if (preTick) begin
      preCnt <= '0;
      if (periodEnd) begin
        cycCnt   <= '0;
        periodSh <= periodLive;
        activeSh <= activeLive;
      end else begin
        cycCnt <= cycCnt + 1'b1;
      end
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  assign activeLvl = strobe.run && (cycCnt < activeSh);
  assign waveLvl   = activeLvl ? strobe.polNormal : ~strobe.polNormal;
  assign pwmOut    = (strobe.run && strobe.bypass) ? srcClk : waveLvl;

endmodule

// File: rtl/pwm_coded_chan.sv
module pwm_coded_chan
  import pwm_coded_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] regAddr,
  input  logic          wrEn,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData,
  output logic          pwmOut
);

  pwmStrobe_t       strobe;
  logic [CW-1:0]    periodLive;
  logic [CW-1:0]    activeLive;
  logic [CW-1:0]    cycCnt;
  logic [DIV_W-1:0] preCnt;
  logic [CW-1:0]    periodSh;
  logic [CW-1:0]    activeSh;

  pwm_coded_ctrl #(.CW(CW), .DW(DW), .AW(AW)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .regAddr    (regAddr),
    .wrEn       (wrEn),
    .wrData     (wrData),
    .rdData     (rdData),
    .strobe     (strobe),
    .periodLive (periodLive),
    .activeLive (activeLive)
  );

  pwm_coded_dp #(.CW(CW), .VW(DIV_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .srcClk     (clk),
    .strobe     (strobe),
    .periodLive (periodLive),
    .activeLive (activeLive),
    .pwmOut     (pwmOut),
    .cycCnt     (cycCnt),
    .preCnt     (preCnt),
    .periodSh   (periodSh),
    .activeSh   (activeSh)
  );

endmodule

// File: rtl/pwm_coded_chk.sv
module pwm_coded_chk
  import pwm_coded_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input logic             clk,
  input logic             rstN,
  input logic [AW-1:0]    regAddr,
  input logic [DW-1:0]    rdData,
  input logic             pwmOut,
  input pwmStrobe_t       strobe,
  input logic [CW-1:0]    cycCnt,
  input logic [DIV_W-1:0] preCnt,
  input logic [CW-1:0]    periodSh,
  input logic [CW-1:0]    activeSh
);

  a_r2_unused_addr_zero: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == AW'(3)) |-> (rdData == '0));

  a_r3_idle_counters_zero: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.run |=> (cycCnt == '0 && preCnt == '0));

  a_r3_idle_inactive: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.run |-> (pwmOut == !strobe.polNormal));

  a_r6_cycle_in_period: assert property (@(posedge clk) disable iff (!rstN)
    strobe.run |-> (cycCnt <= periodSh));

  a_r8_zero_active: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.run && !strobe.bypass && activeSh == '0) |-> (pwmOut == !strobe.polNormal));

  a_r8_full_active: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.run && !strobe.bypass && activeSh > periodSh) |-> (pwmOut == strobe.polNormal));

  a_r10_shadow_hold: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.run && $past(strobe.run) && cycCnt != '0) |-> ($stable(periodSh) && $stable(activeSh)));

endmodule

bind pwm_coded_chan pwm_coded_chk #(.CW(CW), .DW(DW), .AW(AW)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regAddr  (regAddr),
  .rdData   (rdData),
  .pwmOut   (pwmOut),
  .strobe   (strobe),
  .cycCnt   (cycCnt),
  .preCnt   (preCnt),
  .periodSh (periodSh),
  .activeSh (activeSh)
);

// File: tb/pwm_coded_chan_tb.sv
module pwm_coded_chan_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  regAddr = '0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        pwmOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  pwm_coded_chan u_dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .pwmOut(pwmOut)
  );

  // Reference model state, built from the requirements.
  logic [7:0]  mCtrl = '0;
  logic [15:0] mPer = '0, mAct = '0;
  int          mPre = 0, mCyc = 0, mPerS = 0, mActS = 0;

  function automatic int ratioOf(input logic [3:0] c);
    case (c)
      4'd0: return 120;    4'd1: return 180;    4'd2: return 240;
      4'd3: return 360;    4'd4: return 480;    4'd8: return 12000;
      4'd9: return 24000;  4'd10: return 36000; 4'd11: return 48000;
      4'd12: return 72000; default: return 1;
    endcase
  endfunction

  function automatic logic expOut();
    logic runs = mCtrl[0] & mCtrl[1];
    logic pol  = mCtrl[3];
    if (runs && mCyc < mActS) return pol;
    return ~pol;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mCtrl <= '0; mPer <= '0; mAct <= '0;
      mPre <= 0; mCyc <= 0; mPerS <= 0; mActS <= 0;
    end else begin
      if (wrEn) begin
        if (regAddr == 2'd0) mCtrl <= wrData[7:0];
        if (regAddr == 2'd1) mPer  <= wrData[15:0];
        if (regAddr == 2'd2) mAct  <= wrData[15:0];
      end
      if (!(mCtrl[0] & mCtrl[1])) begin
        mPre <= 0; mCyc <= 0; mPerS <= int'(mPer); mActS <= int'(mAct);
      end else if (mPre >= ratioOf(mCtrl[7:4]) - 1) begin
        mPre <= 0;
        if (mCyc == mPerS) begin
          mCyc <= 0; mPerS <= int'(mPer); mActS <= int'(mAct);
        end else mCyc <= mCyc + 1;
      end else mPre <= mPre + 1;
    end
  end

  task automatic report(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readCheck(input logic [1:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    regAddr = a;
    #2;
    report(req, rdData, exp);
  endtask

  task automatic watchOut(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #5;
      report(req, {31'd0, pwmOut}, {31'd0, expOut()});
    end
  endtask

  task automatic startChan(input logic [3:0] code, input logic pol, input logic [15:0] per, input logic [15:0] act);
    regWrite(2'd0, 32'h0);
    regWrite(2'd1, {16'd0, per});
    regWrite(2'd2, {16'd0, act});
    regWrite(2'd0, {24'd0, code, pol, 3'b010});
    regWrite(2'd0, {24'd0, code, pol, 3'b011});
  endtask

  initial begin
    #(20 * 195000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [3:0] smallCodes [8] = '{4'd15, 4'd5, 4'd6, 4'd7, 4'd13, 4'd14, 4'd0, 4'd1};
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1 reset state
    readCheck(2'd0, 32'h0, "R1");
    readCheck(2'd1, 32'h0, "R1");
    readCheck(2'd2, 32'h0, "R1");
    #1; report("R1", {31'd0, pwmOut}, 32'd1);

    // R2 read-back with masking
    regWrite(2'd1, 32'hDEAD_BEEF); readCheck(2'd1, 32'h0000_BEEF, "R2");
    regWrite(2'd2, 32'h1234_5678); readCheck(2'd2, 32'h0000_5678, "R2");
    regWrite(2'd0, 32'hFFFF_FFF8); readCheck(2'd0, 32'h0000_00F8, "R2");
    regWrite(2'd3, 32'hFFFF_FFFF); readCheck(2'd3, 32'h0, "R2");
    readCheck(2'd0, 32'h0000_00F8, "R2");

    // R3 gate only, then enable only: no waveform
    regWrite(2'd1, 32'd3); regWrite(2'd2, 32'd2);
    regWrite(2'd0, 32'h0000_00FA); watchOut(12, "R3");
    regWrite(2'd0, 32'h0000_00F9); watchOut(12, "R3");

    // R6/R7/R9 directed: divide 1, period 5 cycles, 2 active, both polarities
    startChan(4'd15, 1'b1, 16'd4, 16'd2); watchOut(22, "R7");
    startChan(4'd15, 1'b0, 16'd4, 16'd2); watchOut(22, "R9");

    // R8 edge cases
    startChan(4'd15, 1'b1, 16'd6, 16'd0); watchOut(16, "R8");
    startChan(4'd15, 1'b1, 16'd6, 16'd7); watchOut(16, "R8");
    startChan(4'd15, 1'b0, 16'd6, 16'd300); watchOut(16, "R8");

    // R10 mid-period rewrite is deferred to the boundary
    startChan(4'd15, 1'b1, 16'd9, 16'd3);
    watchOut(4, "R10");
    regWrite(2'd1, 32'd4); regWrite(2'd2, 32'd1);
    watchOut(24, "R10");
    regWrite(2'd1, 32'd2); regWrite(2'd2, 32'd2);
    watchOut(12, "R10");

    // R4 small prescaler ratios
    for (int c = 0; c < 5; c++) begin
      startChan(4'(c), 1'b1, 16'd1, 16'd1);
      watchOut(2 * ratioOf(4'(c)) + 4, "R4");
    end

    // R5 and R6 randomised over divide-by-1 and small ratios
    for (int it = 0; it < 16; it++) begin
      logic [3:0]  code = smallCodes[$urandom_range(0, 7)];
      logic [15:0] per  = 16'($urandom_range(0, 7));
      logic [15:0] act  = 16'($urandom_range(0, 10));
      logic        pol  = 1'($urandom_range(0, 1));
      startChan(code, pol, per, act);
      watchOut((int'(per) + 1) * ratioOf(code) * 2 + 3, (ratioOf(code) == 1) ? "R5" : "R6");
    end

    // R4 large ratios
    startChan(4'd8, 1'b1, 16'd1, 16'd1);  watchOut(12004, "R4");
    startChan(4'd12, 1'b1, 16'd1, 16'd1); watchOut(72004, "R4");

    // R11 bypass follows the clock, other settings ignored
    startChan(4'd12, 1'b0, 16'd9, 16'd0);
    regWrite(2'd0, 32'h0000_00C7);
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #5; report("R11", {31'd0, pwmOut}, 32'd1);
      @(negedge clk); #5; report("R11", {31'd0, pwmOut}, 32'd0);
      if (i == 2) regWrite(2'd2, 32'd5);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule